// File: doc/BRIEF.md
# Programmable Baud Rate Divider

This block turns a reference tick into the 16x baud clock of a serial port. The host supplies a 16-bit divisor as two byte writes, one to a low latch and one to a high latch. The block counts reference ticks against that divisor and produces an output level whose period is the divisor, measured in reference ticks. Its frequency is therefore sixteen times the wanted baud rate.

Each write to either latch restarts the count at once. A freshly programmed divisor therefore takes effect within one tick instead of after a long leftover count. For divisors of 3 and above, the output is low for the first two ticks of each period and high for the rest. Divisors 0, 1 and 2 have dedicated waveforms. The whole block runs on one system clock, and the reference tick is a one-cycle enable.

Top module: `baud_divider`

## Requirements
- R1: The divisor is {high latch, low latch}. A write with `wrLo` replaces only bits 7:0, and a write with `wrHi` replaces only bits 15:8. The other byte keeps its value.
- R2: After reset both latches hold 0, the output is low, and the block runs the divisor-0 waveform from the start of a period.
- R3: A write to either latch starts a new period. The output is low in the clock cycle after the write, and the tick count restarts from zero.
- R4: For a divisor D of 3 or more, the output period is D ticks. After the period starts, the output is low for the first 2 ticks and high for the remaining D-2 ticks.
- R5: With a divisor of 2, the output is low for 1 tick and high for 1 tick.
- R6: With a divisor of 1, the output inverts on every reference tick.
- R7: With a divisor of 0, the output period is 3 ticks, with 2 ticks low and 1 tick high.
- R8: The output changes only in the cycle after a tick or a write. In cycles with neither, it holds its value.
- R9: When a write and a tick occur in the same cycle, the write wins. That tick is not counted in the new period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| refTick | input | 1 | One-cycle reference tick enable |
| wrLo | input | 1 | Write strobe for divisor bits 7:0 |
| wrHi | input | 1 | Write strobe for divisor bits 15:8 |
| wrData | input | 8 | Byte written to the selected latch |
| baudOut | output | 1 | 16x baud output level |

## Verification
The assertions assume that `refTick` is a synchronous enable, sampled only at clock edges, and that any value on the write strobes in any cycle is legal. They also assume that a simultaneous tick and write resolve in favour of the write. The stimulus drives every input on the falling clock edge and keeps each tick to a single cycle, separated by idle cycles. In those idle cycles, the hold rule and the low-after-write rule can be observed apart from counting.

// File: rtl/baud_div_pkg.sv
package baud_div_pkg;
  typedef struct packed {
    logic reload;  // restart period from new divisor
    logic wrap;    // terminal count on a tick: reload from held divisor
    logic dec;     // ordinary tick: count down
    logic step;    // tick that advances the period (no write)
  } divCtl_t;
endpackage

// File: rtl/baud_div_ctrl.sv
module baud_div_ctrl
  import baud_div_pkg::*;
(
  input  logic    refTick,
  input  logic    wrLo,
  input  logic    wrHi,
  input  logic    atOne,
  output divCtl_t ctl
);
  logic anyWrite;

  always_comb begin
    anyWrite   = wrLo | wrHi;
    ctl.reload = anyWrite;
    ctl.step   = refTick & ~anyWrite;
    ctl.wrap   = ctl.step & atOne;
    ctl.dec    = ctl.step & ~atOne;
  end
endmodule

// File: rtl/baud_div_dp.sv
module baud_div_dp
  import baud_div_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int NUM_LANES = 2,
  localparam int DIV_W = NUM_LANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  divCtl_t           ctl,
  input  logic              wrLo,
  input  logic              wrHi,
  input  logic [BYTE_W-1:0] wrData,
  output logic              atOne,
  output logic [DIV_W-1:0]  divQ,
  output logic [DIV_W-1:0]  cntQ,
  output logic              baudOut
);
  logic [NUM_LANES-1:0] wrLane;
  logic [DIV_W-1:0]     nextDiv;
  logic [DIV_W-1:0]     effNow;
  logic                 toggleQ;
  logic                 lowPhase;

  function automatic logic [DIV_W-1:0] effOf(input logic [DIV_W-1:0] d);
    return (d == '0) ? DIV_W'(3) : d;
  endfunction

  assign wrLane = {wrHi, wrLo};

  for (genvar i = 0; i < NUM_LANES; i++) begin : gLane
    assign nextDiv[i*BYTE_W +: BYTE_W] = wrLane[i] ? wrData : divQ[i*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divQ    <= '0;
      cntQ    <= DIV_W'(3);
      toggleQ <= 1'b0;
    end else begin
      divQ <= nextDiv;
      if (ctl.reload)    cntQ <= effOf(nextDiv);
      else if (ctl.wrap) cntQ <= effOf(divQ);
      else if (ctl.dec)  cntQ <= cntQ - DIV_W'(1);
      if (ctl.reload)    toggleQ <= 1'b0;
      else if (ctl.step) toggleQ <= ~toggleQ;
    end
  end

  always_comb begin
    effNow   = effOf(divQ);
    atOne    = (cntQ == DIV_W'(1));
    lowPhase = (cntQ == effNow) ||
               ((effNow >= DIV_W'(3)) && (cntQ == effNow - DIV_W'(1)));
    baudOut  = (divQ == DIV_W'(1)) ? toggleQ : ~lowPhase;
  end
endmodule

// File: rtl/baud_divider.sv
module baud_divider
  import baud_div_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int DIV_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refTick,
  input  logic              wrLo,
  input  logic              wrHi,
  input  logic [BYTE_W-1:0] wrData,
  output logic              baudOut
);
  divCtl_t          ctl;
  logic             atOne;
  logic [DIV_W-1:0] divQ;
  logic [DIV_W-1:0] cntQ;

  baud_div_ctrl uCtrl (
    .refTick(refTick), .wrLo(wrLo), .wrHi(wrHi), .atOne(atOne), .ctl(ctl)
  );

  baud_div_dp #(.BYTE_W(BYTE_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrLo(wrLo), .wrHi(wrHi),
    .wrData(wrData), .atOne(atOne), .divQ(divQ), .cntQ(cntQ), .baudOut(baudOut)
  );
endmodule

// File: rtl/baud_divider_chk.sv
module baud_divider_chk #(
  parameter int BYTE_W = 8,
  localparam int DIV_W = 2 * BYTE_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              refTick,
  input logic              wrLo,
  input logic              wrHi,
  input logic [BYTE_W-1:0] wrData,
  input logic              baudOut,
  input logic [DIV_W-1:0]  divQ,
  input logic [DIV_W-1:0]  cntQ
);
  logic [DIV_W-1:0] effChk;
  assign effChk = (divQ == '0) ? DIV_W'(3) : divQ;

  // R1: each strobe lands its byte in its own half
  a_r1_lo_byte: assert property (@(posedge clk) disable iff (!rstN)
    wrLo |=> divQ[BYTE_W-1:0] == $past(wrData));
  a_r1_hi_byte: assert property (@(posedge clk) disable iff (!rstN)
    wrHi |=> divQ[DIV_W-1:BYTE_W] == $past(wrData));

  // R3: output is low right after any write
  a_r3_low_after_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrLo || wrHi) |=> !baudOut);

  // R8: nothing happens without a tick or a write
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!refTick && !wrLo && !wrHi) |=> $stable(baudOut));

  // R6: divisor 1 inverts on every counted tick
  a_r6_toggle: assert property (@(posedge clk) disable iff (!rstN)
    (divQ == DIV_W'(1) && refTick && !wrLo && !wrHi) |=> baudOut != $past(baudOut));

  // R4: counter stays inside one period
  a_r4_cnt_range: assert property (@(posedge clk) disable iff (!rstN)
    (cntQ != '0) && (cntQ <= effChk));
endmodule

bind baud_divider baud_divider_chk #(.BYTE_W(BYTE_W)) uChk (
  .clk(clk), .rstN(rstN), .refTick(refTick), .wrLo(wrLo), .wrHi(wrHi),
  .wrData(wrData), .baudOut(baudOut), .divQ(divQ), .cntQ(cntQ)
);

// File: tb/tb_baud_divider.sv
module tb_baud_divider;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       refTick = 1'b0;
  logic       wrLo = 1'b0;
  logic       wrHi = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       baudOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  baud_divider dut (
    .clk(clk), .rstN(rstN), .refTick(refTick), .wrLo(wrLo), .wrHi(wrHi),
    .wrData(wrData), .baudOut(baudOut)
  );

  function automatic logic expOut(int eff, int k);
    int ph;
    if (eff == 1) return logic'(k % 2);
    ph = k % eff;
    if (eff == 2) return ph != 0;
    return ph >= 2;
  endfunction

  task automatic check(logic got, logic exp, string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: baudOut=%b expected %b", tag, got, exp);
    end
  endtask

  task automatic writeLo(logic [7:0] v);
    @(negedge clk); wrLo = 1'b1; wrData = v;
    @(negedge clk); wrLo = 1'b0;
  endtask

  task automatic writeHi(logic [7:0] v);
    @(negedge clk); wrHi = 1'b1; wrData = v;
    @(negedge clk); wrHi = 1'b0;
  endtask

  task automatic oneTick();
    @(negedge clk); refTick = 1'b1;
    @(negedge clk); refTick = 1'b0;
  endtask

  // run n ticks from start of period, checking each step
  task automatic runPeriod(int eff, int n, string tag);
    check(baudOut, expOut(eff, 0), tag);
    for (int k = 1; k <= n; k++) begin
      oneTick();
      check(baudOut, expOut(eff, k), tag);
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    check(baudOut, 1'b0, "R2 reset low");
    runPeriod(3, 7, "R2 reset divisor 0");
  endtask

  task automatic testDivisor(logic [15:0] d, int n, string tag);
    writeHi(d[15:8]);
    writeLo(d[7:0]);
    check(baudOut, 1'b0, "R3 low after write");
    runPeriod((d == 0) ? 3 : int'(d), n, tag);
  endtask

  task automatic testByteLanes();
    writeLo(8'd5);
    writeHi(8'd1);
    runPeriod(261, 530, "R1 high byte 261");
    writeHi(8'd0);
    runPeriod(5, 12, "R1 low byte kept");
  endtask

  task automatic testHold();
    writeHi(8'd0);
    writeLo(8'd6);
    oneTick(); oneTick(); oneTick();
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(baudOut, expOut(6, 3), "R8 hold without tick");
    end
    oneTick(); oneTick();
    writeLo(8'd6);
    check(baudOut, 1'b0, "R3 restart mid-period");
    runPeriod(6, 8, "R3 restart sequence");
  endtask

  task automatic testCollision();
    writeHi(8'd0);
    writeLo(8'd4);
    oneTick(); oneTick();
    @(negedge clk); refTick = 1'b1; wrLo = 1'b1; wrData = 8'd4;
    @(negedge clk); refTick = 1'b0; wrLo = 1'b0;
    runPeriod(4, 9, "R9 write beats tick");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testDivisor(16'd5, 12, "R4 divisor 5");
    testDivisor(16'd3, 9, "R4 divisor 3");
    testDivisor(16'd2, 6, "R5 divisor 2");
    testDivisor(16'd1, 6, "R6 divisor 1");
    testDivisor(16'd0, 9, "R7 divisor 0");
    testByteLanes();
    testHold();
    testCollision();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule